// File: doc/BRIEF.md
# Wired Interrupt to Doorbell Message Translator

This block watches a vector of wired interrupt lines and, for every line that software has configured, turns line activity into posted memory-write messages. Each message is an address/data pair aimed at one of two 64-bit doorbell addresses. One doorbell raises an interrupt in a downstream controller and the other lowers it. The message data is the target interrupt number held in that line's configuration word.

Software programs the block through a plain 32-bit register port. Each line has its own configuration word, which holds a target number, an enable bit, an edge/level flag and a group field. Edge lines send a single raise message per rising edge. Level lines report each change of level, with a raise message when the line goes high and a lower message when it goes low. Pending lines are served one at a time by a round-robin arbiter. Only group 0 reaches the doorbells. Events from lines in any other group are consumed silently.

The message output is a valid/ready channel. A message is presented with `msg_valid` high. It transfers on a clock edge where `msg_ready` is also high. While `msg_valid` is high and `msg_ready` is low, the address and data hold steady. The next message may follow on the cycle right after a transfer. Register reads are combinational from `reg_addr`. Writes take effect on the clock edge where `reg_wr` is high.

Top module: `wmt_top`

## Requirements
- R1: After reset, `msg_valid` is low and every doorbell register and configuration word reads as zero.
- R2: The raise doorbell is held at byte offsets 0x10 (bits 31:0) and 0x14 (bits 63:32). The lower doorbell is held at 0x18 (bits 31:0) and 0x1C (bits 63:32). All four words read back what was written.
- R3: The configuration word for line x is at byte offset 0x100 + 4*x for x from 0 to NUM_IN-1 (default 207). Its fields are: target number in bits 9:0, enable in bit 24, edge mode in bit 28 (0 means level), and group in bits 31:29. All other bits read as 0. Writes to a word for x >= NUM_IN are ignored, and such words read as 0.
- R4: For an enabled edge line in group 0, a rising edge produces exactly one message, with address = raise doorbell and data = target number zero-extended to 32 bits. A falling edge produces nothing.
- R5: For an enabled level line in group 0, going high produces one message to the raise doorbell and going low produces one message to the lower doorbell. Both carry the target number.
- R6: A line whose enable bit is 0 (including a word of all zeros) produces no messages. Every new message is preceded by an arbiter grant.
- R7: A line configured with a group other than 0 produces no messages.
- R8: When several lines are pending, service is round-robin. The next line served is the lowest pending index above the last served index, wrapping to the lowest pending index. Every grant goes to a line that is pending.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` stay unchanged.
- R10: Several rising edges on one edge line before it is served produce a single message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IN | Wired interrupt lines, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_addr | output | 64 | Doorbell address of the message |
| msg_data | output | 32 | Target interrupt number of the message |

## Verification
On every cycle, the assertions check three things: that a stalled message stays frozen, that message data never carries bits above the target field, and that the arbiter grants only lines that are pending. They also check that no message appears without a grant in the cycle before. Only the bench scenarios can show the rest. That includes which doorbell a given edge or level change selects, that disabled lines and lines in other groups stay silent, that repeated edges coalesce into one message, and the exact rotation order across a stall.

// File: rtl/wmt_pkg.sv
package wmt_pkg;
  parameter int TGT_W    = 10;
  localparam int EN_BIT   = 24;
  localparam int EDGE_BIT = 28;
  localparam int GRP_LSB  = 29;
  localparam logic [2:0] GRP_DOORBELL = 3'd0;

  typedef struct packed {
    logic [2:0]       grp;
    logic             edge_md;
    logic             en;
    logic [TGT_W-1:0] tgt;
  } cfg_t;

  function automatic logic [31:0] cfg_pack(cfg_t c);
    logic [31:0] r;
    r = '0;
    r[TGT_W-1:0]    = c.tgt;
    r[EN_BIT]       = c.en;
    r[EDGE_BIT]     = c.edge_md;
    r[31:GRP_LSB]   = c.grp;
    return r;
  endfunction
endpackage

// File: rtl/wmt_regs.sv
module wmt_regs
  import wmt_pkg::*;
#(
  parameter int NUM_IN = 207,
  parameter int AW     = 12,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output cfg_t             cfg_q [NUM_IN],
  output logic [63:0]      set_db,
  output logic [63:0]      clr_db,
  output logic             cfg_wr,
  output logic [IDX_W-1:0] cfg_wr_idx
);
  localparam logic [AW-1:0] CFG_BASE = AW'('h100);

  logic [31:0]   set_lo, set_hi, clr_lo, clr_hi;
  logic [AW-1:0] idx_full;
  logic          in_cfg;
  logic [IDX_W-1:0] idx;

  assign idx_full = (reg_addr - CFG_BASE) >> 2;
  assign in_cfg   = (reg_addr >= CFG_BASE) && (reg_addr[1:0] == 2'b00) &&
                    (idx_full < AW'(NUM_IN));
  assign idx      = idx_full[IDX_W-1:0];

  assign cfg_wr     = reg_wr && in_cfg;
  assign cfg_wr_idx = idx;
  assign set_db     = {set_hi, set_lo};
  assign clr_db     = {clr_hi, clr_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_lo <= '0; set_hi <= '0; clr_lo <= '0; clr_hi <= '0;
      for (int i = 0; i < NUM_IN; i++) cfg_q[i] <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        AW'('h10): set_lo <= reg_wdata;
        AW'('h14): set_hi <= reg_wdata;
        AW'('h18): clr_lo <= reg_wdata;
        AW'('h1C): clr_hi <= reg_wdata;
        default: begin
          if (in_cfg) begin
            cfg_q[idx].tgt     <= reg_wdata[TGT_W-1:0];
            cfg_q[idx].en      <= reg_wdata[EN_BIT];
            cfg_q[idx].edge_md <= reg_wdata[EDGE_BIT];
            cfg_q[idx].grp     <= reg_wdata[31:GRP_LSB];
          end
        end
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'('h10): reg_rdata = set_lo;
      AW'('h14): reg_rdata = set_hi;
      AW'('h18): reg_rdata = clr_lo;
      AW'('h1C): reg_rdata = clr_hi;
      default:   if (in_cfg) reg_rdata = cfg_pack(cfg_q[idx]);
    endcase
  end
endmodule

// File: rtl/wmt_detect.sv
module wmt_detect #(
  parameter int NUM_IN = 207,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] en,
  input  logic [NUM_IN-1:0] edge_md,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_wr_idx,
  input  logic              take,
  input  logic [IDX_W-1:0]  take_idx,
  output logic [NUM_IN-1:0] req,
  output logic [NUM_IN-1:0] is_set
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_line
    logic prev_q, pend_q, rep_q;
    logic reconf, served;
    assign reconf = cfg_wr && (cfg_wr_idx == IDX_W'(i));
    assign served = take && (take_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b0; pend_q <= 1'b0; rep_q <= 1'b0;
      end else begin
        prev_q <= irq_in[i];
        if (reconf || !en[i]) begin
          pend_q <= 1'b0;
          rep_q  <= 1'b0;
        end else if (edge_md[i]) begin
          rep_q <= 1'b0;
          if (irq_in[i] && !prev_q) pend_q <= 1'b1;
          else if (served)          pend_q <= 1'b0;
        end else begin
          pend_q <= 1'b0;
          if (served) rep_q <= irq_in[i];
        end
      end
    end

    assign req[i]    = en[i] && (edge_md[i] ? pend_q : (irq_in[i] != rep_q));
    assign is_set[i] = edge_md[i] || irq_in[i];
  end
endmodule

// File: rtl/wmt_rr_arb.sv
module wmt_rr_arb #(
  parameter int NUM_IN = 207,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] req,
  input  logic              take,
  output logic              gnt_valid,
  output logic [IDX_W-1:0]  gnt_idx
);
  logic [IDX_W-1:0] last_q;
  logic             hi_v, lo_v;
  logic [IDX_W-1:0] hi_i, lo_i;

  always_comb begin
    hi_v = 1'b0; lo_v = 1'b0; hi_i = '0; lo_i = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (req[i]) begin
        lo_v = 1'b1;
        lo_i = IDX_W'(i);
        if (IDX_W'(i) > last_q) begin
          hi_v = 1'b1;
          hi_i = IDX_W'(i);
        end
      end
    end
  end

  assign gnt_valid = lo_v;
  assign gnt_idx   = hi_v ? hi_i : lo_i;

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= IDX_W'(NUM_IN - 1);
    else if (take) last_q <= gnt_idx;
  end
endmodule

// File: rtl/wmt_top.sv
module wmt_top
  import wmt_pkg::*;
#(
  parameter int NUM_IN = 207,
  parameter int AW     = 12,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  cfg_t              cfg_q [NUM_IN];
  logic [63:0]       set_db, clr_db;
  logic              cfg_wr;
  logic [IDX_W-1:0]  cfg_wr_idx;
  logic [NUM_IN-1:0] en_v, edge_v, req, is_set;
  logic              gnt_valid, take, emit, can_load;
  logic [IDX_W-1:0]  gnt_idx;

  wmt_regs #(.NUM_IN(NUM_IN), .AW(AW)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .cfg_q, .set_db, .clr_db, .cfg_wr, .cfg_wr_idx
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_flags
    assign en_v[i]   = cfg_q[i].en;
    assign edge_v[i] = cfg_q[i].edge_md;
  end

  wmt_detect #(.NUM_IN(NUM_IN)) u_detect (
    .clk, .rst_n, .irq_in, .en(en_v), .edge_md(edge_v),
    .cfg_wr, .cfg_wr_idx, .take, .take_idx(gnt_idx),
    .req, .is_set
  );

  wmt_rr_arb #(.NUM_IN(NUM_IN)) u_arb (
    .clk, .rst_n, .req, .take, .gnt_valid, .gnt_idx
  );

  assign can_load = !msg_valid || msg_ready;
  assign take     = gnt_valid && can_load;
  assign emit     = take && (cfg_q[gnt_idx].grp == GRP_DOORBELL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (can_load) begin
      msg_valid <= emit;
      if (emit) begin
        msg_addr <= is_set[gnt_idx] ? set_db : clr_db;
        msg_data <= 32'(cfg_q[gnt_idx].tgt);
      end
    end
  end
endmodule

// File: rtl/wmt_chk.sv
module wmt_chk
  import wmt_pkg::*;
#(
  parameter int NUM_IN = 207,
  localparam int IDX_W = $clog2(NUM_IN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [63:0]       msg_addr,
  input logic [31:0]       msg_data,
  input logic              gnt_valid,
  input logic [IDX_W-1:0]  gnt_idx,
  input logic [NUM_IN-1:0] req,
  input logic              take
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R4
  data_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[31:TGT_W] == '0));

  // R8
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req[gnt_idx]);

  // R6
  msg_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(take));
endmodule

bind wmt_top wmt_chk #(.NUM_IN(NUM_IN)) i_wmt_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .gnt_valid(gnt_valid),
  .gnt_idx(gnt_idx), .req(req), .take(take)
);

// File: tb/test_wmt_top.sv
`timescale 1ns/1ps
module test_wmt_top;
  localparam int NUM_IN = 207;
  localparam int AW = 12;
  localparam logic [63:0] SET_DB = 64'h0000_00AB_CDEF_0040;
  localparam logic [63:0] CLR_DB = 64'h0000_00AB_CDEF_0048;
  localparam logic [31:0] EN   = 32'h0100_0000;
  localparam logic [31:0] EDGE = 32'h1000_0000;

  logic clk = 0, rst_n = 0;
  logic [NUM_IN-1:0] irq_in = '0;
  logic reg_wr = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msg_valid, msg_ready = 1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int n_run = 0, n_fail = 0, n_msg = 0;
  logic [63:0] ma [8];
  logic [31:0] md [8];
  bit done = 0;

  always #5 clk = ~clk;

  wmt_top #(.NUM_IN(NUM_IN), .AW(AW)) i_wmt_top (
    .clk, .rst_n, .irq_in, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .msg_valid, .msg_ready, .msg_addr, .msg_data
  );

  function automatic logic [31:0] exp_cfg(int idx, logic [31:0] w);
    return (idx < NUM_IN) ? (w & 32'hF100_03FF) : 32'h0;
  endfunction

  function automatic logic [AW-1:0] cfg_addr(int idx);
    return AW'(32'h100 + 4 * idx);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NUM_IN-1:0] m);
    @(posedge clk); #1; irq_in = irq_in | m;
    @(posedge clk); #1; irq_in = irq_in & ~m;
  endtask

  task automatic set_line(input int i, input logic v);
    @(posedge clk); #1; irq_in[i] = v;
  endtask

  task automatic collect(input int cycles);
    n_msg = 0;
    @(posedge clk); #1; msg_ready = 1;
    repeat (cycles) begin
      @(negedge clk);
      if (msg_valid && n_msg < 8) begin
        ma[n_msg] = msg_addr; md[n_msg] = msg_data; n_msg++;
      end
    end
  endtask

  task automatic expect_one(input string tag, input logic [63:0] a, input logic [31:0] d);
    check(n_msg == 1, tag, 64'(n_msg), 64'd1);
    if (n_msg >= 1) begin
      check(ma[0] == a, tag, ma[0], a);
      check(md[0] == d, tag, 64'(md[0]), 64'(d));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w;
    int idx;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    @(negedge clk);
    check(msg_valid == 0, "R1 msg_valid", 64'(msg_valid), 0);
    rd(AW'('h10), d); check(d == 0, "R1 set_lo", 64'(d), 0);
    rd(AW'('h1C), d); check(d == 0, "R1 clr_hi", 64'(d), 0);
    rd(cfg_addr(0), d);   check(d == 0, "R1 cfg0", 64'(d), 0);
    rd(cfg_addr(206), d); check(d == 0, "R1 cfg206", 64'(d), 0);

    // R2 doorbells
    wr(AW'('h10), SET_DB[31:0]); wr(AW'('h14), SET_DB[63:32]);
    wr(AW'('h18), CLR_DB[31:0]); wr(AW'('h1C), CLR_DB[63:32]);
    rd(AW'('h10), d); check(d == SET_DB[31:0],  "R2 set_lo", 64'(d), 64'(SET_DB[31:0]));
    rd(AW'('h14), d); check(d == SET_DB[63:32], "R2 set_hi", 64'(d), 64'(SET_DB[63:32]));
    rd(AW'('h18), d); check(d == CLR_DB[31:0],  "R2 clr_lo", 64'(d), 64'(CLR_DB[31:0]));
    rd(AW'('h1C), d); check(d == CLR_DB[63:32], "R2 clr_hi", 64'(d), 64'(CLR_DB[63:32]));

    // R3 random config write/readback, including out-of-range indices
    for (int k = 0; k < 40; k++) begin
      idx = (k == 0) ? 206 : (k == 1) ? 207 : int'($urandom_range(0, 255));
      w = $urandom;
      wr(cfg_addr(idx), w);
      rd(cfg_addr(idx), d);
      check(d == exp_cfg(idx, w), "R3 cfg readback", 64'(d), 64'(exp_cfg(idx, w)));
    end
    for (int i = 0; i < NUM_IN; i++) wr(cfg_addr(i), 32'h0);
    rd(cfg_addr(206), d); check(d == 0, "R3 cfg cleared", 64'(d), 0);

    // R4 edge line
    wr(cfg_addr(5), EN | EDGE | 32'h55);
    pulse(NUM_IN'(1) << 5);
    collect(12);
    expect_one("R4 edge raise", SET_DB, 32'h55);

    // R5 level line
    wr(cfg_addr(100), EN | 32'h1AB);
    set_line(100, 1); collect(12);
    expect_one("R5 level rise", SET_DB, 32'h1AB);
    set_line(100, 0); collect(12);
    expect_one("R5 level fall", CLR_DB, 32'h1AB);

    // R6 disabled lines
    wr(cfg_addr(7), EDGE | 32'h77);
    pulse(NUM_IN'(1) << 7); collect(12);
    check(n_msg == 0, "R6 enable clear", 64'(n_msg), 0);
    set_line(8, 1); collect(12);
    check(n_msg == 0, "R6 zero word", 64'(n_msg), 0);
    set_line(8, 0);

    // R7 non-zero groups
    wr(cfg_addr(9), (32'd4 << 29) | EN | EDGE | 32'h99);
    pulse(NUM_IN'(1) << 9); collect(12);
    check(n_msg == 0, "R7 group 4", 64'(n_msg), 0);
    wr(cfg_addr(10), (32'd1 << 29) | EN | 32'h3A);
    set_line(10, 1); collect(12);
    check(n_msg == 0, "R7 group 1 rise", 64'(n_msg), 0);
    set_line(10, 0); collect(12);
    check(n_msg == 0, "R7 group 1 fall", 64'(n_msg), 0);

    // R8 and R9: round robin across a stall
    wr(cfg_addr(1), EN | EDGE | 32'h1);
    wr(cfg_addr(2), EN | EDGE | 32'h2);
    wr(cfg_addr(3), EN | EDGE | 32'h3);
    @(posedge clk); #1 msg_ready = 0;
    pulse(NUM_IN'('b1110));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(msg_valid && msg_data == 1, "R9 stalled head", 64'(msg_data), 64'd1);
    pulse(NUM_IN'('b0010));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(msg_valid && msg_data == 1 && msg_addr == SET_DB, "R9 held stable", 64'(msg_data), 64'd1);
    collect(12);
    check(n_msg == 4, "R8 message count", 64'(n_msg), 64'd4);
    if (n_msg == 4) begin
      check(md[0] == 1, "R8 order 0", 64'(md[0]), 1);
      check(md[1] == 2, "R8 order 1", 64'(md[1]), 2);
      check(md[2] == 3, "R8 order 2", 64'(md[2]), 3);
      check(md[3] == 1, "R8 order 3", 64'(md[3]), 1);
    end

    // R10 coalescing of repeated edges
    @(posedge clk); #1 msg_ready = 0;
    pulse(NUM_IN'('b0100));
    repeat (2) @(posedge clk);
    repeat (3) pulse(NUM_IN'(1) << 5);
    collect(12);
    check(n_msg == 2, "R10 count", 64'(n_msg), 64'd2);
    if (n_msg == 2) check(md[1] == 32'h55, "R10 data", 64'(md[1]), 64'h55);

    // R4/R5 random lines and targets
    for (int k = 0; k < 30; k++) begin
      int li;
      logic [9:0] tgt;
      bit is_edge;
      li = int'($urandom_range(11, 206));
      tgt = 10'($urandom);
      is_edge = 1'($urandom);
      wr(cfg_addr(li), EN | (is_edge ? EDGE : 32'h0) | 32'(tgt));
      if (is_edge) begin
        pulse(NUM_IN'(1) << li); collect(10);
        expect_one("R4 random edge", SET_DB, 32'(tgt));
      end else begin
        set_line(li, 1); collect(10);
        expect_one("R5 random rise", SET_DB, 32'(tgt));
        set_line(li, 0); collect(10);
        expect_one("R5 random fall", CLR_DB, 32'(tgt));
      end
      wr(cfg_addr(li), 32'h0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule